// File: doc/BRIEF.md
# Serial Input Capture FIFO Controller

This block buffers words arriving from a serial input port until a processor core collects them. Words enter through a valid/ready input side. The core uses a small register window to program the block, read status and pop words from an eight-entry queue. The core sees words in the order they arrived.

The core programs a fill threshold. A level interrupt stays high while the queue holds more words than that threshold. A hang-disable bit selects the behaviour at the queue's edges. With stalling on, a data read from an empty queue holds the core's bus access, and an offer on a full queue holds the input side. With stalling off, an empty read returns zero, and an offer on a full queue is dropped and sets a sticky overflow flag.

The queue is emptied when the port enable is turned off, or when software writes the flush command bit. A global DMA enable bit is passed straight out to the DMA logic.

Top module: `sin_fifo_ctrl`

## Requirements
- R1: Register address 0 is the control register. It holds the threshold N in bits [3:0], hang-disable in bit 4, DMA enable in bit 5 and port enable in bit 7. Bit 6 always reads 0. Address 1 always reads 0. All fields are 0 after reset. reg_rdata is 0 whenever reg_rd is low.
- R2: thresh_irq is high exactly while N is at most 7 and the fill level exceeds N.
- R3: When hang-disable is 0, a read of address 2 from an empty queue raises reg_stall until a word is present. When hang-disable is 0 and the port is enabled, in_ready is low while the queue holds 8 words.
- R4: When hang-disable is 1, reg_stall stays low. A read of address 2 from an empty queue returns 0 and removes nothing. An offer to a full queue is dropped and sets the overflow flag.
- R5: The overflow flag is sticky and is cleared by a control write with bit 6 set. A new overflow in the same cycle wins over the clear.
- R6: While the port enable is 0, offered words are discarded, in_ready is high and the overflow flag is unaffected.
- R7: A control write that changes the port enable from 1 to 0 empties the queue on that clock edge.
- R8: A write to address 1 with bit 31 set empties the queue on that clock edge. This flush wins over a word accepted in the same cycle.
- R9: A read of address 2 returns the oldest word and removes it. A read of address 3 returns the fill level in bits [7:4] and the overflow flag in bit 0.
- R10: dma_en_o follows control bit 5 from the clock edge of the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input side offers a word |
| in_data | input | DATA_W | Offered word |
| in_ready | output | 1 | Low while the input side is held on a full queue |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 command, 2 data, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| reg_stall | output | 1 | Holds the core's read of an empty queue |
| thresh_irq | output | 1 | Fill level above threshold |
| ovf_flag | output | 1 | Sticky overflow flag |
| dma_en_o | output | 1 | Global DMA enable |

## Verification
The assertions assume that reg_wr and reg_rd are never asserted in the same cycle. They also assume that a stalled requester simply retries, because no property depends on the requester holding its request. The reference model drives exactly one register access, or none, per cycle, and it re-evaluates every output each cycle whatever the stall state. Offers and accesses on a full or empty queue are therefore legal stimulus and are compared like any other cycle.

// File: rtl/sinf_pkg.sv
package sinf_pkg;
    localparam int BUS_W     = 32;
    localparam int NSET_W    = 4;
    localparam int B_HANGDIS = 4;
    localparam int B_DMA     = 5;
    localparam int B_CLROVF  = 6;
    localparam int B_PORTEN  = 7;
    localparam int B_FLUSH   = 31;
    localparam int STAT_SH   = 4;

    typedef enum logic [1:0] {
        REG_CTL  = 2'd0,
        REG_CMD  = 2'd1,
        REG_DATA = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              port_en;
        logic              dma_en;
        logic              hang_dis;
        logic [NSET_W-1:0] nset;
    } ctl_t;
endpackage

// File: rtl/sinf_mem.sv
module sinf_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == PTR_W'(i))) begin
                slot[i] <= wdata;
            end
        end
    end

    assign rdata = slot[raddr];
endmodule

// File: rtl/sinf_thresh.sv
module sinf_thresh #(
    parameter int CNT_W  = 4,
    parameter int NSET_W = 4,
    parameter int MAX_N  = 7
) (
    input  logic [CNT_W-1:0]  fill,
    input  logic [NSET_W-1:0] nset,
    output logic              irq
);
    logic n_usable;
    logic above;

    always_comb begin
        n_usable = (int'(nset) <= MAX_N);
        above    = (int'(fill) > int'(nset));
        irq      = n_usable && above;
    end
endmodule

// File: rtl/sin_fifo_ctrl.sv
module sin_fifo_ctrl #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_stall,
    output logic              thresh_irq,
    output logic              ovf_flag,
    output logic              dma_en_o
);
    import sinf_pkg::*;

    // DEPTH is a power of two so the pointers wrap by overflow; DATA_W <= 32.
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int MAX_N = DEPTH - 1;

    typedef struct packed {
        logic [PTR_W-1:0] rptr;
        logic [PTR_W-1:0] wptr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        ctl_t             ctl;
    } st_t;

    st_t s_d, s_q;

    logic              ctl_wr, cmd_wr, data_rd;
    logic              empty, full;
    logic              push_try, push, pop, ovf_hit, flush;
    logic [DATA_W-1:0] head;

    // visible to the bound checker
    logic [CNT_W-1:0]  fill_lvl;
    logic [NSET_W-1:0] thr_n;
    logic              port_en, hang_dis;

    wire unused_wdata = ^{reg_wdata[30:8]};

    always_comb begin
        ctl_wr  = reg_wr && (reg_addr == REG_CTL);
        cmd_wr  = reg_wr && (reg_addr == REG_CMD);
        data_rd = reg_rd && (reg_addr == REG_DATA);
        empty   = (s_q.cnt == '0);
        full    = (s_q.cnt == CNT_W'(DEPTH));

        push_try = in_valid && s_q.ctl.port_en;
        push     = push_try && !full;
        ovf_hit  = push_try && full && s_q.ctl.hang_dis;
        pop      = data_rd && !empty;
        flush    = (ctl_wr && s_q.ctl.port_en && !reg_wdata[B_PORTEN])
                 || (cmd_wr && reg_wdata[B_FLUSH]);

        s_d = s_q;

        if (ctl_wr) begin
            s_d.ctl.port_en  = reg_wdata[B_PORTEN];
            s_d.ctl.dma_en   = reg_wdata[B_DMA];
            s_d.ctl.hang_dis = reg_wdata[B_HANGDIS];
            s_d.ctl.nset     = reg_wdata[NSET_W-1:0];
            if (reg_wdata[B_CLROVF]) begin
                s_d.ovf = 1'b0;
            end
        end
        if (ovf_hit) begin
            s_d.ovf = 1'b1;
        end

        if (flush) begin
            s_d.rptr = '0;
            s_d.wptr = '0;
            s_d.cnt  = '0;
        end else begin
            if (push) begin
                s_d.wptr = s_q.wptr + 1'b1;
            end
            if (pop) begin
                s_d.rptr = s_q.rptr + 1'b1;
            end
            if (push && !pop) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end else if (pop && !push) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    sinf_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_mem (
        .clk   (clk),
        .we    (push && !flush),
        .waddr (s_q.wptr),
        .wdata (in_data),
        .raddr (s_q.rptr),
        .rdata (head)
    );

    sinf_thresh #(
        .CNT_W  (CNT_W),
        .NSET_W (NSET_W),
        .MAX_N  (MAX_N)
    ) u_thr (
        .fill (s_q.cnt),
        .nset (s_q.ctl.nset),
        .irq  (thresh_irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                REG_CTL:  reg_rdata = {24'd0, s_q.ctl.port_en, 1'b0, s_q.ctl.dma_en,
                                       s_q.ctl.hang_dis, s_q.ctl.nset};
                REG_CMD:  reg_rdata = '0;
                REG_DATA: reg_rdata = empty ? '0 : BUS_W'(head);
                REG_STAT: reg_rdata = (BUS_W'(s_q.cnt) << STAT_SH) | BUS_W'(s_q.ovf);
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign reg_stall = data_rd && empty && !s_q.ctl.hang_dis;
    assign in_ready  = !(s_q.ctl.port_en && full && !s_q.ctl.hang_dis);
    assign ovf_flag  = s_q.ovf;
    assign dma_en_o  = s_q.ctl.dma_en;
    assign fill_lvl  = s_q.cnt;
    assign thr_n     = s_q.ctl.nset;
    assign port_en   = s_q.ctl.port_en;
    assign hang_dis  = s_q.ctl.hang_dis;
endmodule

// File: rtl/sinf_chk.sv
module sinf_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             wd_en,
    input logic             wd_clr,
    input logic             wd_dma,
    input logic             wd_flush,
    input logic             reg_stall,
    input logic             in_ready,
    input logic             thresh_irq,
    input logic             ovf_flag,
    input logic             dma_en_o,
    input logic [CNT_W-1:0] fill,
    input logic [3:0]       thr_n,
    input logic             port_en,
    input logic             hang_dis
);
    assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    assert_irq_big_n_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_n > 4'd7) |-> !thresh_irq);

    assert_irq_low_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill <= CNT_W'(thr_n)) |-> !thresh_irq);

    assert_stall_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_stall |-> (fill == '0));

    assert_hold_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (fill == CNT_W'(DEPTH)));

    assert_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hang_dis |-> (!reg_stall && in_ready));

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(reg_wr && reg_addr == 2'd0 && wd_clr)) |=> ovf_flag);

    assert_no_fill_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (fill <= $past(fill)));

    assert_flush_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && port_en && !wd_en) |=> (fill == '0));

    assert_flush_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && wd_flush) |=> (fill == '0));

    assert_dma_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=> (dma_en_o == $past(wd_dma)));
endmodule

bind sin_fifo_ctrl sinf_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .wd_en      (reg_wdata[7]),
    .wd_clr     (reg_wdata[6]),
    .wd_dma     (reg_wdata[5]),
    .wd_flush   (reg_wdata[31]),
    .reg_stall  (reg_stall),
    .in_ready   (in_ready),
    .thresh_irq (thresh_irq),
    .ovf_flag   (ovf_flag),
    .dma_en_o   (dma_en_o),
    .fill       (fill_lvl),
    .thr_n      (thr_n),
    .port_en    (port_en),
    .hang_dis   (hang_dis)
);

// File: tb/sim_sin_fifo_ctrl.sv
module sim_sin_fifo_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_stall, thresh_irq, ovf_flag, dma_en_o;

    int total = 0;
    int bad = 0;

    // reference model state
    logic [31:0] q[$];
    logic        m_en = 0, m_dma = 0, m_hd = 0, m_ovf = 0;
    logic [3:0]  m_nset = 0;

    logic [31:0] last_rd;
    logic        last_stall, last_rdy;

    always #5 clk = ~clk;

    sin_fifo_ctrl #(.DATA_W(32), .DEPTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_stall(reg_stall),
        .thresh_irq(thresh_irq), .ovf_flag(ovf_flag), .dma_en_o(dma_en_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // one clock cycle: drive, compare combinational outputs, advance model
    task automatic cyc(input logic iv, input logic [31:0] id, input logic wr,
                       input logic rd, input logic [1:0] a, input logic [31:0] wd);
        logic empty, full, push, pop, ovf_hit, flush;
        logic [31:0] exp_rd;
        in_valid = iv; in_data = id; reg_wr = wr; reg_rd = rd;
        reg_addr = a; reg_wdata = wd;
        #1;
        empty = (q.size() == 0);
        full  = (q.size() == 8);
        exp_rd = 0;
        if (rd) begin
            case (a)
                2'd0: exp_rd = {24'd0, m_en, 1'b0, m_dma, m_hd, m_nset};
                2'd1: exp_rd = 0;
                2'd2: exp_rd = empty ? 32'd0 : q[0];
                default: exp_rd = (32'(q.size()) << 4) | 32'(m_ovf);
            endcase
        end
        chk("R9 rdata", reg_rdata, exp_rd);
        chk("R3 stall", 32'(reg_stall), 32'(rd && a == 2'd2 && empty && !m_hd));
        chk("R3 in_ready", 32'(in_ready), 32'(!(m_en && full && !m_hd)));
        chk("R2 irq", 32'(thresh_irq), 32'(m_nset <= 7 && q.size() > int'(m_nset)));
        chk("R5 ovf", 32'(ovf_flag), 32'(m_ovf));
        chk("R10 dma", 32'(dma_en_o), 32'(m_dma));
        last_rd = reg_rdata; last_stall = reg_stall; last_rdy = in_ready;

        push    = iv && m_en && !full;
        ovf_hit = iv && m_en && full && m_hd;
        pop     = rd && a == 2'd2 && !empty;
        flush   = (wr && a == 2'd0 && m_en && !wd[7]) || (wr && a == 2'd1 && wd[31]);
        @(posedge clk);
        if (wr && a == 2'd0) begin
            m_en = wd[7]; m_dma = wd[5]; m_hd = wd[4]; m_nset = wd[3:0];
            if (wd[6]) m_ovf = 0;
        end
        if (ovf_hit) m_ovf = 1;
        if (flush) q.delete();
        else begin
            if (pop) void'(q.pop_front());
            if (push) q.push_back(id);
        end
        @(negedge clk);
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask
    task automatic push_w(input logic [31:0] d); cyc(1, d, 0, 0, 0, 0); endtask
    task automatic rd_reg(input logic [1:0] a); cyc(0, 0, 0, 1, a, 0); endtask
    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d); cyc(0, 0, 1, 0, a, d); endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd_reg(0);  chk("R1 ctl reset", last_rd, 32'h0);
        rd_reg(3);  chk("R9 stat reset", last_rd, 32'h0);

        // port disabled: offers vanish
        for (int i = 0; i < 3; i++) push_w(32'hA100 + i);
        chk("R6 ready while off", 32'(last_rdy), 1);
        rd_reg(3);  chk("R6 nothing entered", last_rd, 32'h0);

        // enable, dma, no hang, N=3
        wr_reg(0, 32'hB3);
        rd_reg(0);  chk("R1 ctl readback", last_rd, 32'hB3);
        chk("R10 dma out", 32'(dma_en_o), 1);
        for (int i = 1; i <= 3; i++) push_w(32'h1000 + i);
        chk("R2 irq at N", 32'(thresh_irq), 0);
        push_w(32'h1004);
        chk("R2 irq above N", 32'(thresh_irq), 1);
        rd_reg(2);  chk("R9 oldest first", last_rd, 32'h1001);
        rd_reg(2);  chk("R9 second", last_rd, 32'h1002);

        // fill and overflow with stalling off
        for (int i = 5; i <= 10; i++) push_w(32'h1000 + i);
        push_w(32'hDEAD);
        chk("R4 overflow flag", 32'(ovf_flag), 1);
        rd_reg(3);  chk("R4 word dropped", last_rd, 32'h81);
        wr_reg(0, 32'hF3);
        chk("R5 ovf cleared", 32'(ovf_flag), 0);
        rd_reg(0);  chk("R1 clear bit reads 0", last_rd, 32'hB3);
        // set wins over clear
        cyc(1, 32'hBEEF, 1, 0, 0, 32'hF3);
        chk("R5 set beats clear", 32'(ovf_flag), 1);
        wr_reg(0, 32'hF3);

        for (int i = 3; i <= 10; i++) begin
            rd_reg(2); chk("R9 drain order", last_rd, 32'h1000 + i);
        end
        rd_reg(2);
        chk("R4 empty read zero", last_rd, 0);
        chk("R4 no stall", 32'(last_stall), 0);
        rd_reg(3);  chk("R4 still empty", last_rd, 0);

        // N above 7 never interrupts
        wr_reg(0, 32'hB9);
        for (int i = 0; i < 8; i++) push_w(32'h2000 + i);
        chk("R2 suppressed N=9", 32'(thresh_irq), 0);

        // command flush, and flush beats same-cycle push
        wr_reg(1, 32'h8000_0000);
        rd_reg(3);  chk("R8 flushed", last_rd, 0);
        push_w(32'h3001); push_w(32'h3002);
        cyc(1, 32'h3003, 1, 0, 1, 32'h8000_0000);
        rd_reg(3);  chk("R8 flush beats push", last_rd, 0);
        rd_reg(1);  chk("R8 command reads 0", last_rd, 0);

        // stalling enabled
        wr_reg(0, 32'hA3);
        rd_reg(2);  chk("R3 empty read stalls", 32'(last_stall), 1);
        cyc(1, 32'h4000, 0, 1, 2, 0);
        chk("R3 still stalled", 32'(last_stall), 1);
        rd_reg(2);
        chk("R3 stall released", 32'(last_stall), 0);
        chk("R3 word delivered", last_rd, 32'h4000);
        for (int i = 0; i < 8; i++) push_w(32'h5000 + i);
        push_w(32'h5FFF);
        chk("R3 full holds input", 32'(last_rdy), 0);
        rd_reg(3);  chk("R3 no overflow", last_rd, 32'h80);

        // disable flushes
        wr_reg(0, 32'h23);
        rd_reg(3);  chk("R7 disable flush", last_rd, 0);
        chk("R10 dma kept", 32'(dma_en_o), 1);
        wr_reg(0, 32'hB3);
        push_w(32'h6001);
        cyc(1, 32'h6002, 1, 0, 0, 32'h33);
        rd_reg(3);  chk("R7 flush beats push", last_rd, 0);
        wr_reg(0, 32'h93);
        chk("R10 dma off", 32'(dma_en_o), 0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [31:0] w;
            op = $urandom_range(0, 11);
            w  = $urandom;
            case (op)
                0, 1, 2, 3: cyc(w[0], $urandom, 0, 1, 2, 0);
                4:          cyc(w[0], $urandom, 0, 1, 3, 0);
                5:          cyc(w[0], $urandom, 0, 1, 0, 0);
                6:          cyc(w[0], $urandom, 0, 1, 1, 0);
                7:          cyc(w[0], $urandom, 1, 0, 0,
                                {24'd0, (w[10:8] != 0), w[6:0]});
                8:          cyc(w[0], $urandom, 1, 0, 1, {w[31] & w[30], 31'd0});
                default:    cyc(1, $urandom, 0, 0, 0, 0);
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule